// File: doc/BRIEF.md
# Single-Bin DFT Correlator

This block measures one frequency component of a sampled response. After a start request it paces sample acquisition at one sixteenth of the system clock, multiplies each accepted 12-bit signed sample by the cosine and the negated sine of a running phase, and adds the products into two wide accumulators. The phase runs from the same tuning word that sets the excitation tone. So the block only ever evaluates the bin that sits on the present excitation frequency, and it never performs a full transform.

One measurement always takes 1024 accepted samples. The in-phase and quadrature sums then appear on the outputs together with a one-cycle completion pulse, and they stay there until the next measurement is started. Bin spacing is the sample rate divided by 1024. A result is clean only when the 1024 samples cover a whole number of excitation periods. Under that condition a constant offset on the input cancels out of both sums.

Top module: `dft_bin_correlator`

## Requirements
- R1: After reset, `done` is low and both `re_sum` and `im_sum` read zero.
- R2: A `start` seen while idle clears both sums, zeroes the phase and begins a measurement. A `start` seen while a measurement is running changes nothing in that measurement.
- R3: Each sum is a 40-bit two's-complement value. 1024 products of full-scale samples and full-scale coefficients give the exact total, with no wrap.
- R4: A sample is taken only at the clock edges 16, 32, 48, ... after the edge that accepted `start`, and only when `sample_en` is high at that edge. A slot with `sample_en` low is skipped and does not count. `adc_sample` is ignored at all other edges.
- R5: A measurement accumulates exactly 1024 accepted samples, then stops.
- R6: The phase register is 27 bits wide. It starts at zero and advances by the captured step after each accepted sample. For each sample the address is the top 10 bits of the phase before the advance, and the coefficients are round(32767·cos(2πa/1024)) and −round(32767·sin(2πa/1024)).
- R7: `re_sum` is the sum of sample×cosine and `im_sum` is the sum of sample×negated sine. The sample is read as a 12-bit two's-complement value.
- R8: `done` is high for exactly one cycle. It rises after the second clock edge that follows the edge accepting the 1024th sample, and the sums are final in that same cycle.
- R9: After `done`, the sums hold their values until the next accepted `start`.
- R10: `phase_step` is captured when `start` is accepted. Later changes to it have no effect on the running measurement.
- R11: A constant input, measured at a nonzero bin whose 1024 samples cover a whole number of periods, gives sums below 2^21 in magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a measurement (ignored while busy) |
| phase_step | input | 27 | Phase increment per sample, shared with the excitation generator |
| sample_en | input | 1 | Sample is valid at the current pacing slot |
| adc_sample | input | 12 | Signed ADC code |
| re_sum | output | 40 | In-phase accumulation |
| im_sum | output | 40 | Quadrature accumulation |
| done | output | 1 | One-cycle completion pulse |

## Verification
The embedded properties assume three things: `start` arrives as a pulse, reset comes before any activity, and a new measurement is started only after the previous completion pulse. The stimulus raises `start` while idle only after `done` has been seen. The one deliberate overlapping `start` is used to show that the block ignores it. The input values it drives are always legal 12-bit codes. It places random values on `adc_sample` in every cycle that is not a pacing slot, and in skipped slots, so that a sample taken at the wrong time would change the expected sums.

// File: rtl/dft_pkg.sv
// Package: shared widths and counts for the single-bin correlator.
// Assumes: sample count is a power of two no larger than the 11-bit count range.
package dft_pkg;
    localparam int SAMPLE_W  = 12;
    localparam int COEF_W    = 16;
    localparam int PHASE_W   = 27;
    localparam int ADDR_W    = 10;
    localparam int N_SAMPLES = 1024;
    localparam int CLK_DIV   = 16;
    localparam int ACC_W     = 40;
    localparam int PROD_W    = SAMPLE_W + COEF_W;
    localparam int CNT_W     = $clog2(N_SAMPLES + 1);
endpackage

// File: rtl/dft_pacer.sv
// Module: dft_pacer
// Produces a single-cycle sample tick every DIV clocks while run is high.
// Assumes: clr is pulsed at measurement start so the first tick lands DIV edges later.
module dft_pacer #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic tick
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    logic [DW-1:0] div_cnt;

    // Divider counter: restarts on clr, wraps at DIV-1 while running.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                     div_cnt <= '0;
        else if (run && div_cnt == DW'(DIV-1)) div_cnt <= '0;
        else if (run)                          div_cnt <= div_cnt + 1'b1;
    end

    assign tick = run && (div_cnt == DW'(DIV-1));

    // R4: pacing ticks never come back to back.
    p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/dft_phasor_lut.sv
// Module: dft_phasor_lut
// Registered cosine and negated-sine lookup built from a quarter-wave table.
// Assumes: the table is computed at elaboration; amplitude is 2^(COEF_W-1)-1.
module dft_phasor_lut #(
    parameter int ADDR_W = 10,
    parameter int COEF_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic [ADDR_W-1:0]        addr,
    output logic signed [COEF_W-1:0] cos_q,
    output logic signed [COEF_W-1:0] msin_q
);
    localparam int QBITS = ADDR_W - 2;
    localparam int QLEN  = 1 << QBITS;
    localparam real AMP  = real'((1 << (COEF_W-1)) - 1);

    // Sine of a quarter-wave point by series expansion, rounded to an integer.
    function automatic int quarter_val(input int k);
        real x, term, s;
        x = 3.141592653589793 * real'(k) / (2.0 * real'(QLEN));
        term = x;
        s = 0.0;
        for (int n = 0; n < 12; n++) begin
            s = s + term;
            term = -term * x * x / (real'(2*n + 2) * real'(2*n + 3));
        end
        return $rtoi(AMP * s + 0.5);
    endfunction

    logic [COEF_W-1:0] qrom [0:QLEN];

    for (genvar i = 0; i <= QLEN; i++) begin : g_qrom
        localparam int QV = quarter_val(i);
        assign qrom[i] = COEF_W'(QV);
    end

    // Full-wave sine from the quarter table using quadrant folding.
    function automatic logic signed [COEF_W-1:0] full_sin(input logic [ADDR_W-1:0] a);
        logic [QBITS:0] idx;
        logic [COEF_W-1:0] mag;
        idx = a[ADDR_W-2] ? ((QBITS+1)'(QLEN) - {1'b0, a[QBITS-1:0]}) : {1'b0, a[QBITS-1:0]};
        mag = qrom[idx];
        return a[ADDR_W-1] ? -$signed(mag) : $signed(mag);
    endfunction

    logic [ADDR_W-1:0] addr_cos;
    assign addr_cos = addr + ADDR_W'(QLEN);

    // Output register: cosine and negated sine of the presented address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cos_q  <= '0;
            msin_q <= '0;
        end else if (en) begin
            cos_q  <= full_sin(addr_cos);
            msin_q <= -full_sin(addr);
        end
    end

    // R6: coefficients stay within the symmetric amplitude range.
    p_coef_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cos_q != {1'b1, {(COEF_W-1){1'b0}}}) && (msin_q != {1'b1, {(COEF_W-1){1'b0}}}));
endmodule

// File: rtl/dft_mac.sv
// Module: dft_mac
// Two-stage complex multiply-accumulate: product register, then accumulator.
// Assumes: clr only arrives while the pipeline is empty.
module dft_mac #(
    parameter int SAMPLE_W = 12,
    parameter int COEF_W   = 16,
    parameter int ACC_W    = 40
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       in_vld,
    input  logic                       in_last,
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic signed [COEF_W-1:0]   cosv,
    input  logic signed [COEF_W-1:0]   msinv,
    output logic signed [ACC_W-1:0]    acc_re,
    output logic signed [ACC_W-1:0]    acc_im,
    output logic                       done
);
    localparam int PROD_W = SAMPLE_W + COEF_W;
    logic signed [PROD_W-1:0] prod_re, prod_im;
    logic                     pv, pl;

    // Product stage: signed multiply of sample by both coefficients.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            prod_re <= '0;
            prod_im <= '0;
            pv      <= 1'b0;
            pl      <= 1'b0;
        end else begin
            pv <= in_vld;
            pl <= in_vld && in_last;
            if (in_vld) begin
                prod_re <= sample * cosv;
                prod_im <= sample * msinv;
            end
        end
    end

    // Accumulate stage: add products, flag completion on the final one.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_re <= '0;
            acc_im <= '0;
            done   <= 1'b0;
        end else begin
            done <= pv && pl;
            if (pv) begin
                acc_re <= acc_re + ACC_W'(prod_re);
                acc_im <= acc_im + ACC_W'(prod_im);
            end
        end
    end

    // R8: the completion pulse lasts a single cycle.
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R3: an accumulate never flips sign against a same-signed product (no wrap).
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pv && !clr && (acc_re[ACC_W-1] == prod_re[PROD_W-1]))
            |=> (acc_re[ACC_W-1] == $past(acc_re[ACC_W-1])));
endmodule

// File: rtl/dft_bin_correlator.sv
// Module: dft_bin_correlator (top)
// Correlates 1024 paced samples against the phasor of the excitation tuning word.
// Assumes: start is a pulse; a new start is honoured only when idle.
module dft_bin_correlator
    import dft_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [PHASE_W-1:0]        phase_step,
    input  logic                      sample_en,
    input  logic [SAMPLE_W-1:0]       adc_sample,
    output logic signed [ACC_W-1:0]   re_sum,
    output logic signed [ACC_W-1:0]   im_sum,
    output logic                      done
);
    logic                       busy, go, tick, take, run;
    logic [PHASE_W-1:0]         step_q, phase;
    logic [CNT_W-1:0]           issued;
    logic signed [SAMPLE_W-1:0] sample_q;
    logic signed [COEF_W-1:0]   cos_c, msin_c;
    logic                       v1, last1;

    assign go   = start && !busy;
    assign run  = busy && (issued < CNT_W'(N_SAMPLES));
    assign take = tick && sample_en;

    // Measurement state: busy from an accepted start until completion.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy <= 1'b0;
        else if (go)   busy <= 1'b1;
        else if (done) busy <= 1'b0;
    end

    // Step capture and phase accumulation per accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
            phase  <= '0;
        end else if (go) begin
            step_q <= phase_step;
            phase  <= '0;
        end else if (take) begin
            phase  <= phase + step_q;
        end
    end

    // Sample counter and first pipeline stage alongside the lookup.
    always_ff @(posedge clk) begin
        if (!rst_n || go) begin
            issued   <= '0;
            sample_q <= '0;
            v1       <= 1'b0;
            last1    <= 1'b0;
        end else begin
            v1    <= take;
            last1 <= take && (issued == CNT_W'(N_SAMPLES-1));
            if (take) begin
                issued   <= issued + 1'b1;
                sample_q <= $signed(adc_sample);
            end
        end
    end

    dft_pacer #(.DIV(CLK_DIV)) u_pacer (
        .clk(clk), .rst_n(rst_n), .clr(go), .run(run), .tick(tick)
    );

    dft_phasor_lut #(.ADDR_W(ADDR_W), .COEF_W(COEF_W)) u_lut (
        .clk(clk), .rst_n(rst_n), .en(take),
        .addr(phase[PHASE_W-1 -: ADDR_W]),
        .cos_q(cos_c), .msin_q(msin_c)
    );

    dft_mac #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_mac (
        .clk(clk), .rst_n(rst_n), .clr(go),
        .in_vld(v1), .in_last(last1),
        .sample(sample_q), .cosv(cos_c), .msinv(msin_c),
        .acc_re(re_sum), .acc_im(im_sum), .done(done)
    );

    // R6: an accepted start leaves the phase at zero.
    p_phase_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (phase == '0));
    // R10: the captured step stays fixed throughout a measurement.
    p_step_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !go) |=> $stable(step_q));
    // R2: a start while busy does not reset the sample count.
    p_busy_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && issued != '0) |=> (issued != '0));
    // R5: never more than N samples accepted.
    p_count_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        issued <= CNT_W'(N_SAMPLES));
    // R9: results hold while idle and no start arrives.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(re_sum) && $stable(im_sum)));
endmodule

// File: tb/sim_dft_bin_correlator.sv
module sim_dft_bin_correlator;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [26:0] phase_step = '0;
    logic sample_en = 1'b0;
    logic [11:0] adc_sample = '0;
    logic signed [39:0] re_sum, im_sum;
    logic done;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dft_bin_correlator u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .phase_step(phase_step),
        .sample_en(sample_en), .adc_sample(adc_sample),
        .re_sum(re_sum), .im_sum(im_sum), .done(done)
    );

    function automatic longint rnd(input real x);
        return (x >= 0.0) ? longint'($rtoi(x + 0.5)) : -longint'($rtoi(-x + 0.5));
    endfunction

    // Input pattern generator: mode picks waveform, j is accepted-sample index.
    function automatic int gen(input int mode, input int k, input int j);
        real a;
        a = 2.0 * 3.141592653589793 * real'(k) * real'(j) / 1024.0;
        case (mode)
            0: return int'(rnd(1800.0 * $cos(a)));
            1: return 1500;
            2: return -2048;
            3: return int'(rnd(1700.0 * $sin(a)));
            default: return ((j * 37) % 4096) - 2048;
        endcase
    endfunction

    task automatic chk(input string req, input longint got, input longint exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    longint exp_re = 0, exp_im = 0;

    // One measurement with its behavioural model; compared every clock.
    task automatic run(input int mode, input int k, input logic [26:0] step,
                       input int skip_every, input bit disturb);
        longint ph = 0;
        int issued = 0, last_c = -100, slot = 0;
        bit fin = 0;
        int hold = 0;
        @(negedge clk);
        start = 1'b1;
        phase_step = step;
        @(posedge clk);
        exp_re = 0;
        exp_im = 0;
        for (int c = 1; c < 20000; c++) begin
            @(negedge clk);
            start = 1'b0;
            // R8 / R5: done exactly two edges after the 1024th acceptance edge.
            chk("R8 done timing", longint'(done), longint'(issued == 1024 && (c-1) == last_c + 2));
            if (issued == 1024 && (c-1) == last_c + 2) fin = 1;
            if (fin) begin
                // R7 / R6 / R3 / R9: results exact at done and held afterwards.
                chk("R7 re_sum", longint'(re_sum), exp_re);
                chk("R7 im_sum", longint'(im_sum), exp_im);
                hold++;
                if (hold == 6) break;
            end
            if (disturb && c == 100) phase_step = 27'h5A5A5A5;   // R10
            if (disturb && c == 3000) start = 1'b1;               // R2
            if (c % 16 == 0 && issued < 1024) begin
                slot++;
                if (skip_every != 0 && slot % skip_every == 0) begin
                    sample_en = 1'b0;                             // R4 skipped slot
                    adc_sample = 12'($urandom);
                end else begin
                    int s, a;
                    real ang;
                    s = gen(mode, k, issued);
                    a = int'(ph >> 17);
                    ang = 2.0 * 3.141592653589793 * real'(a) / 1024.0;
                    exp_re += longint'(s) * rnd(32767.0 * $cos(ang));
                    exp_im += longint'(s) * (-rnd(32767.0 * $sin(ang)));
                    ph = (ph + longint'(step)) % (longint'(1) << 27);
                    sample_en = 1'b1;
                    adc_sample = 12'(s);
                    issued++;
                    last_c = c;
                end
            end else begin
                sample_en = 1'b1;                                  // R4 off-slot garbage
                adc_sample = 12'($urandom);
            end
        end
        chk("R5 measurement completed", longint'(fin), 1);
        @(negedge clk);
        chk("R9 hold re", longint'(re_sum), exp_re);
        chk("R9 done low", longint'(done), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 done after reset", longint'(done), 0);
        chk("R1 re_sum after reset", longint'(re_sum), 0);
        chk("R1 im_sum after reset", longint'(im_sum), 0);
        rst_n = 1'b1;
        run(0, 3, 27'(3 * 131072), 0, 0);          // R7 cosine at bin 3
        run(1, 0, 27'(5 * 131072), 0, 0);          // R11 DC at bin 5
        n_vec++;
        if (re_sum > 40'sd2097151 || re_sum < -40'sd2097151 ||
            im_sum > 40'sd2097151 || im_sum < -40'sd2097151) begin
            n_bad++;
            $display("FAIL R11 dc leak: got %0d/%0d expected below 2097152", re_sum, im_sum);
        end
        run(2, 0, 27'd0, 0, 0);                    // R3 full scale, no wrap
        chk("R3 full-scale value", longint'(re_sum), -longint'(2048) * 32767 * 1024);
        run(3, 7, 27'(7 * 131072), 97, 0);         // R4 skipped slots, sine input
        run(4, 0, 27'd12345, 0, 1);                // R2 busy start, R10 step change
        run(0, 1, 27'(131072), 0, 0);              // R2 fresh clear after prior run
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule